// File: doc/BRIEF.md
# SMBus Target Configuration Bridge

This block is a target on a two-wire SMBus segment that turns framed command sequences from a bus host into accesses on a simple internal request/acknowledge register port. The host addresses the target, sends a command byte and a byte count, and then streams field bytes. The field bytes fill an internal frame of four address bytes followed by four data bytes. Once a transfer has been closed, the block raises a request that carries the assembled address, the write data, the direction and the address interpretation. It holds that request until the internal side acknowledges it.

The begin and end flags in the command byte let the host split one access across several SMBus transactions. A transaction whose command carries no begin flag keeps filling the frame where the previous one left off. From the moment an access is launched until it is acknowledged, the target refuses any transaction addressed to it. After a read access completes, the host fetches a status byte and the four read-data bytes with a read transaction. The captured fields have no path to software. Packet error codes are neither generated nor checked.

Top module: `smbt_bridge`

## Requirements
- R1: An address byte whose upper seven bits equal DEV_ADDR is acknowledged (SDA pulled low in the ninth clock) when the block is idle, and bit 0 selects write (0) or read (1). Any other address is not acknowledged, and SDA is left released for the rest of that transaction.
- R2: In a write transaction the first byte after the address is the command, the second is the byte count, and the following bytes fill frame positions in order: addr_o[31:24], [23:16], [15:8], [7:0], then wdata_o[31:24], [23:16], [15:8], [7:0].
- R3: Command bit 0 gives we_o (1 = write access, 0 = read access). Command bit 1 gives mmio_o: 1 means addr_o[31:24] selects the destination and addr_o[23:0] is an offset, and 0 means the four bytes are bus, device/function, extended register and register number.
- R4: A request is raised only at the STOP of a write transaction whose command has the end bit (bit 6) set and that has delivered exactly the counted bytes. req_o and all request fields then stay unchanged until ack_i is high, and req_o drops in the cycle after the acknowledge.
- R5: Command bit 7 (begin) restarts frame filling at position 0. A completed transaction without the end bit raises no request, and the next transaction without the begin bit continues at the following position.
- R6: While a request is outstanding, address bytes for this target are not acknowledged, for both write and read.
- R7: A STOP or START that arrives before the byte count is satisfied raises no request and drops the partly assembled frame, so the next transaction fills from position 0.
- R8: When a read access is acknowledged, rdata_i and sts_i are latched. A later read transaction returns the status byte first, then read data bytes [31:24], [23:16], [15:8], [7:0], and 0xFF for any further byte.
- R9: Command bit 4 (packet error code) has no effect: the transfer behaves the same and no extra byte is expected or sent.
- R10: After reset req_o is low and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; oversamples SCL and SDA |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SMBus clock line |
| sda_i | input | 1 | SMBus data line as seen on the bus |
| sda_oe_o | output | 1 | Pull SDA low when high |
| req_o | output | 1 | Internal access request |
| we_o | output | 1 | Access is a write |
| mmio_o | output | 1 | Address uses memory-mapped interpretation |
| addr_o | output | 32 | Assembled address bytes |
| wdata_o | output | 32 | Assembled write data |
| ack_i | input | 1 | Internal acknowledge, one cycle |
| rdata_i | input | 32 | Read data, valid with ack_i |
| sts_i | input | 8 | Access status, valid with ack_i |

## Verification
A wrong frame pointer shows up at once as shifted or stale bytes in addr_o and wdata_o on the next request. This makes split and aborted transfers the most telling sweeps. A busy flag that is stuck or missing appears within one address byte as a wrong acknowledge bit, and as a missing or duplicated request on the internal port. A link state that drifts by a bit corrupts the first byte read back or drives SDA while SCL is high, and the checker catches the second case in the same cycle.

// File: rtl/smbt_pkg.sv
package smbt_pkg;
  typedef enum logic [2:0] {
    L_IDLE, L_ADDR, L_AACK, L_RX, L_RACK, L_TX, L_MACK
  } link_st_e;

  localparam int unsigned CMD_BEGIN = 7;
  localparam int unsigned CMD_END   = 6;
  localparam int unsigned CMD_MMIO  = 1;
  localparam int unsigned CMD_WR    = 0;
endpackage

// File: rtl/smbt_line_sync.sv
module smbt_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sr, sda_sr;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[STAGES-2:0], scl_i};
      sda_sr <= {sda_sr[STAGES-2:0], sda_i};
      scl_d  <= scl_sr[STAGES-1];
      sda_d  <= sda_sr[STAGES-1];
    end
  end

  assign scl_o      = scl_sr[STAGES-1];
  assign sda_o      = sda_sr[STAGES-1];
  assign scl_rise_o = scl_o && !scl_d;
  assign scl_fall_o = !scl_o && scl_d;
  assign start_o    = scl_o && scl_d && sda_d && !sda_o;
  assign stop_o     = scl_o && scl_d && !sda_d && sda_o;
endmodule

// File: rtl/smbt_link.sv
module smbt_link
  import smbt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h5A
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sda_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       busy_i,
  input  logic [7:0] tx_byte_i,
  output logic       sda_oe_o,
  output logic       addr_ok_o,
  output logic       addr_rw_o,
  output logic       rx_valid_o,
  output logic [7:0] rx_byte_o,
  output logic       tx_load_o
);
  link_st_e   st;
  logic [7:0] sh, tx_sh;
  logic [2:0] cnt;
  logic       full, ack_q, rw_q, mack_q;
  logic       match, byte_end;

  assign match    = (sh[7:1] == DEV_ADDR);
  assign byte_end = scl_fall_i && full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= L_IDLE; sh <= '0; tx_sh <= '1; cnt <= '0;
      full <= 1'b0; ack_q <= 1'b0; rw_q <= 1'b0; mack_q <= 1'b0;
    end else if (start_i) begin
      st <= L_ADDR; cnt <= '0; full <= 1'b0;
    end else if (stop_i) begin
      st <= L_IDLE; full <= 1'b0;
    end else begin
      unique case (st)
        L_ADDR, L_RX: begin
          if (scl_rise_i) begin
            sh  <= {sh[6:0], sda_i};
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7) full <= 1'b1;
          end else if (byte_end) begin
            full <= 1'b0;
            cnt  <= '0;
            if (st == L_RX) st <= L_RACK;
            else if (match) begin
              rw_q  <= sh[0];
              ack_q <= !busy_i;
              st    <= L_AACK;
            end else st <= L_IDLE;
          end
        end
        L_AACK: if (scl_fall_i) begin
          cnt <= '0;
          if (!ack_q) st <= L_IDLE;
          else if (rw_q) begin st <= L_TX; tx_sh <= tx_byte_i; end
          else st <= L_RX;
        end
        L_RACK: if (scl_fall_i) st <= L_RX;
        L_TX: begin
          if (scl_rise_i) begin
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7) full <= 1'b1;
          end else if (byte_end) begin
            full <= 1'b0; cnt <= '0; st <= L_MACK;
          end else if (scl_fall_i) tx_sh <= {tx_sh[6:0], 1'b1};
        end
        L_MACK: begin
          if (scl_rise_i) mack_q <= !sda_i;
          else if (scl_fall_i) begin
            if (mack_q) begin st <= L_TX; tx_sh <= tx_byte_i; end
            else st <= L_IDLE;
          end
        end
        default: st <= L_IDLE;
      endcase
    end
  end

  assign sda_oe_o   = (st == L_AACK && ack_q) || (st == L_RACK) || (st == L_TX && !tx_sh[7]);
  assign addr_ok_o  = !start_i && !stop_i && st == L_ADDR && byte_end && match && !busy_i;
  assign addr_rw_o  = sh[0];
  assign rx_valid_o = !start_i && !stop_i && st == L_RX && byte_end;
  assign rx_byte_o  = sh;
  assign tx_load_o  = !start_i && !stop_i && scl_fall_i &&
                      ((st == L_AACK && ack_q && rw_q) || (st == L_MACK && mack_q));
endmodule

// File: rtl/smbt_fields.sv
module smbt_fields
  import smbt_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 4,
  parameter int unsigned DATA_BYTES = 4,
  localparam int unsigned FIELDS = ADDR_BYTES + DATA_BYTES,
  localparam int unsigned AW = 8 * ADDR_BYTES,
  localparam int unsigned DW = 8 * DATA_BYTES
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          addr_ok_i,
  input  logic          addr_rw_i,
  input  logic          rx_valid_i,
  input  logic [7:0]    rx_byte_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          tx_load_i,
  input  logic          ack_i,
  input  logic [DW-1:0] rdata_i,
  input  logic [7:0]    sts_i,
  output logic [7:0]    tx_byte_o,
  output logic          busy_o,
  output logic          req_o,
  output logic          we_o,
  output logic          mmio_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o
);
  localparam int unsigned PW = $clog2(FIELDS + 1);
  localparam int unsigned IW = $clog2(FIELDS);
  localparam int unsigned TW = $clog2(DATA_BYTES + 2);

  logic [7:0]    fld [FIELDS];
  logic [PW-1:0] ptr;
  logic [7:0]    got, cnt_q;
  logic [8:0]    pos;
  logic [1:0]    phase;
  logic          wr_act, c_end, c_wr, c_mmio;
  logic          req_q, we_q, mmio_q;
  logic [DW-1:0] rd_q;
  logic [7:0]    st_q;
  logic [TW-1:0] tidx;

  assign pos = {{(9-PW){1'b0}}, ptr} + {1'b0, got};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(FIELDS); i++) fld[i] <= '0;
      ptr <= '0; got <= '0; cnt_q <= '0; phase <= '0; wr_act <= 1'b0;
      c_end <= 1'b0; c_wr <= 1'b0; c_mmio <= 1'b0;
      req_q <= 1'b0; we_q <= 1'b0; mmio_q <= 1'b0;
      rd_q <= '0; st_q <= '0; tidx <= '0;
    end else begin
      if (req_q && ack_i) begin
        req_q <= 1'b0;
        if (!we_q) begin rd_q <= rdata_i; st_q <= sts_i; end
      end
      if (addr_ok_i) begin
        if (!addr_rw_i) begin wr_act <= 1'b1; phase <= '0; got <= '0; end
        else tidx <= '0;
      end
      if (tx_load_i && tidx != '1) tidx <= tidx + 1'b1;
      if (rx_valid_i && wr_act) begin
        unique case (phase)
          2'd0: begin
            c_end  <= rx_byte_i[CMD_END];
            c_wr   <= rx_byte_i[CMD_WR];
            c_mmio <= rx_byte_i[CMD_MMIO];
            if (rx_byte_i[CMD_BEGIN]) ptr <= '0;
            phase <= 2'd1;
          end
          2'd1: begin cnt_q <= rx_byte_i; phase <= 2'd2; end
          default: if (got < cnt_q) begin
            if (pos < 9'(FIELDS)) fld[pos[IW-1:0]] <= rx_byte_i;
            got <= got + 8'd1;
          end
        endcase
      end
      if ((stop_i || start_i) && wr_act) begin
        wr_act <= 1'b0;
        if (stop_i && phase == 2'd2 && got == cnt_q) begin
          if (c_end) begin
            req_q <= 1'b1; we_q <= c_wr; mmio_q <= c_mmio; ptr <= '0;
          end else ptr <= (pos > 9'(FIELDS)) ? PW'(FIELDS) : pos[PW-1:0];
        end else ptr <= '0;
      end
    end
  end

  always_comb begin
    tx_byte_o = 8'hFF;
    if (tidx == '0) tx_byte_o = st_q;
    else if (int'(tidx) <= int'(DATA_BYTES))
      tx_byte_o = rd_q[8*(int'(DATA_BYTES) - int'(tidx)) +: 8];
  end

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_addr
    assign addr_o[8*(ADDR_BYTES-1-g) +: 8] = fld[g];
  end
  for (genvar g = 0; g < DATA_BYTES; g++) begin : g_data
    assign wdata_o[8*(DATA_BYTES-1-g) +: 8] = fld[ADDR_BYTES+g];
  end

  assign busy_o = req_q;
  assign req_o  = req_q;
  assign we_o   = we_q;
  assign mmio_o = mmio_q;
endmodule

// File: rtl/smbt_bridge.sv
module smbt_bridge #(
  parameter logic [6:0]  DEV_ADDR    = 7'h5A,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_BYTES  = 4,
  parameter int unsigned DATA_BYTES  = 4,
  localparam int unsigned AW = 8 * ADDR_BYTES,
  localparam int unsigned DW = 8 * DATA_BYTES
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  output logic          req_o,
  output logic          we_o,
  output logic          mmio_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  input  logic          ack_i,
  input  logic [DW-1:0] rdata_i,
  input  logic [7:0]    sts_i
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic busy, addr_ok, addr_rw, rx_valid, tx_load;
  logic [7:0] rx_byte, tx_byte;

  smbt_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_evt), .stop_o(stop_evt)
  );

  smbt_link #(.DEV_ADDR(DEV_ADDR)) u_link (
    .clk_i, .rst_ni, .sda_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_evt), .stop_i(stop_evt), .busy_i(busy), .tx_byte_i(tx_byte),
    .sda_oe_o, .addr_ok_o(addr_ok), .addr_rw_o(addr_rw),
    .rx_valid_o(rx_valid), .rx_byte_o(rx_byte), .tx_load_o(tx_load)
  );

  smbt_fields #(.ADDR_BYTES(ADDR_BYTES), .DATA_BYTES(DATA_BYTES)) u_fields (
    .clk_i, .rst_ni, .addr_ok_i(addr_ok), .addr_rw_i(addr_rw),
    .rx_valid_i(rx_valid), .rx_byte_i(rx_byte), .start_i(start_evt), .stop_i(stop_evt),
    .tx_load_i(tx_load), .ack_i, .rdata_i, .sts_i, .tx_byte_o(tx_byte),
    .busy_o(busy), .req_o, .we_o, .mmio_o, .addr_o, .wdata_o
  );
endmodule

// File: rtl/smbt_chk.sv
module smbt_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          scl_s,
  input logic          sda_oe_o,
  input logic          req_o,
  input logic          ack_i,
  input logic [AW-1:0] addr_o,
  input logic [DW-1:0] wdata_o,
  input logic          stop_evt,
  input logic          addr_ok,
  input logic          busy
);
  // R1: SDA drive only changes while SCL is low
  a_r1_sda_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_s);

  // R4: request raised only on a STOP
  a_r4_req_on_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> $past(stop_evt));

  a_r4_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i |=> req_o && $stable(addr_o) && $stable(wdata_o));

  a_r4_req_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && ack_i |=> !req_o);

  // R6: no address accepted while an access is outstanding
  a_r6_busy_nak: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !addr_ok);
endmodule

bind smbt_bridge smbt_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s(scl_s), .sda_oe_o(sda_oe_o),
  .req_o(req_o), .ack_i(ack_i), .addr_o(addr_o), .wdata_o(wdata_o),
  .stop_evt(stop_evt), .addr_ok(addr_ok), .busy(busy)
);

// File: tb/sim_smbt_bridge.sv
`timescale 1ns/1ps
module sim_smbt_bridge;
  localparam logic [6:0] DEV = 7'h5A;
  localparam int H = 16;
  localparam int Q = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_oe, req, we, mmio, ack = 1'b0;
  logic [31:0] addr, wdata, rdata = '0;
  logic [7:0] sts = '0;
  wire sda_line = sda_m & ~sda_oe;

  int checks = 0, fails = 0, req_cnt = 0;
  bit resp_en = 1'b1;
  logic [31:0] c_addr, c_wdata;
  logic c_we, c_mmio;

  always #4 clk = ~clk;

  smbt_bridge #(.DEV_ADDR(DEV)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .req_o(req), .we_o(we), .mmio_o(mmio), .addr_o(addr), .wdata_o(wdata),
    .ack_i(ack), .rdata_i(rdata), .sts_i(sts)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // internal responder
  initial begin
    forever begin
      @(negedge clk);
      if (req && !ack && resp_en) begin
        c_addr = addr; c_wdata = wdata; c_we = we; c_mmio = mmio;
        req_cnt++;
        cyc(5);
        rdata = c_addr ^ 32'hA5A5_5A5A;
        sts   = c_addr[7:0] ^ 8'h3C;
        ack   = 1'b1;
        cyc(1);
        ack   = 1'b0;
      end
    end
  end

  task automatic m_start();
    sda_m = 1'b1; scl = 1'b1; cyc(H);
    sda_m = 1'b0; cyc(H);
    scl = 1'b0; cyc(Q);
  endtask

  task automatic m_stop();
    cyc(Q); sda_m = 1'b0; cyc(H);
    scl = 1'b1; cyc(H);
    sda_m = 1'b1; cyc(H);
  endtask

  task automatic m_wr(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      cyc(Q); sda_m = b[i]; cyc(H - Q);
      scl = 1'b1; cyc(H);
      scl = 1'b0;
    end
    cyc(Q); sda_m = 1'b1; cyc(H - Q);
    scl = 1'b1; cyc(H / 2);
    acked = !sda_line;
    cyc(H / 2);
    scl = 1'b0;
  endtask

  task automatic m_rd(input bit give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      cyc(H);
      scl = 1'b1; cyc(H / 2);
      b[i] = sda_line;
      cyc(H / 2);
      scl = 1'b0;
    end
    cyc(Q); sda_m = !give_ack; cyc(H - Q);
    scl = 1'b1; cyc(H);
    scl = 1'b0; cyc(Q); sda_m = 1'b1;
  endtask

  // write transaction: cmd, count, then nb field bytes taken from f (field 0 first)
  task automatic m_xfer(input logic [7:0] cmd, input logic [7:0] cnt, input int nb,
                        input logic [63:0] f, output bit aok);
    bit a;
    m_start();
    m_wr({DEV, 1'b0}, aok);
    if (aok) begin
      m_wr(cmd, a);
      m_wr(cnt, a);
      for (int i = 0; i < nb; i++) m_wr(f[63-8*i -: 8], a);
    end
    m_stop();
  endtask

  task automatic check_req(input string tag, input int exp_cnt, input logic [31:0] ea,
                           input logic [31:0] ed, input bit ewe, input bit emm);
    cyc(40);
    chk(req_cnt == exp_cnt, {tag, " count"}, 32'(req_cnt), 32'(exp_cnt));
    chk(c_addr == ea, {tag, " addr"}, c_addr, ea);
    if (ewe) chk(c_wdata == ed, {tag, " wdata"}, c_wdata, ed);
    chk({c_we, c_mmio} == {ewe, emm}, {tag, " we/mmio"}, {30'd0, c_we, c_mmio}, {30'd0, ewe, emm});
  endtask

  initial begin
    bit aok;
    logic [7:0] b;
    logic [31:0] a, d;
    int exp_cnt;
    fork
      begin
        cyc(190000);
        checks++; fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    join_none

    cyc(5);
    chk(!req && !sda_oe, "R10 reset", {30'd0, req, sda_oe}, 32'd0);
    rst_n = 1'b1;
    cyc(10);
    chk(!req && !sda_oe, "R10 after reset", {30'd0, req, sda_oe}, 32'd0);
    exp_cnt = 0;

    // R1: foreign address not acknowledged
    m_start(); m_wr({DEV ^ 7'h01, 1'b0}, aok); m_stop();
    chk(!aok, "R1 foreign address nak", {31'd0, aok}, 32'd0);

    // R2 R3 R9: sweep of full writes in both modes, PEC bit toggled
    for (int k = 0; k < 12; k++) begin
      a = (32'h0102_0304 * (k + 1)) ^ (k << 28);
      d = ~a + 32'(k * 977);
      m_xfer(8'hC1 | (8'(k & 1) << 1) | (8'((k >> 1) & 1) << 4), 8'd8, 8, {a, d}, aok);
      chk(aok, "R1 own address ack", {31'd0, aok}, 32'd1);
      exp_cnt++;
      check_req("R2 R3 R9 write sweep", exp_cnt, a, d, 1'b1, 1'(k & 1));
    end

    // R8: read access then read back status and data
    for (int k = 0; k < 3; k++) begin
      a = 32'h1357_9BDF + 32'(k * 32'h0101_0101);
      m_xfer(8'hC0 | (8'(k & 1) << 1), 8'd4, 4, {a, 32'h0}, aok);
      exp_cnt++;
      check_req("R3 read access", exp_cnt, a, 32'h0, 1'b0, 1'(k & 1));
      m_start(); m_wr({DEV, 1'b1}, aok);
      chk(aok, "R8 read address ack", {31'd0, aok}, 32'd1);
      m_rd(1'b1, b);
      chk(b == (a[7:0] ^ 8'h3C), "R8 status byte", {24'd0, b}, {24'd0, a[7:0] ^ 8'h3C});
      d = a ^ 32'hA5A5_5A5A;
      for (int i = 0; i < 4; i++) begin
        m_rd(1'b1, b);
        chk(b == d[31-8*i -: 8], "R8 read data byte", {24'd0, b}, {24'd0, d[31-8*i -: 8]});
      end
      m_rd(1'b0, b);
      chk(b == 8'hFF, "R8 beyond data", {24'd0, b}, 32'hFF);
      m_stop();
    end

    // R5: split transfer, addresses then data
    a = 32'hCAFE_0042; d = 32'h0BAD_F00D;
    m_xfer(8'h81, 8'd4, 4, {a, 32'h0}, aok);
    cyc(40);
    chk(req_cnt == exp_cnt, "R5 no request without end", 32'(req_cnt), 32'(exp_cnt));
    m_xfer(8'h41, 8'd4, 4, {d, 32'h0}, aok);
    exp_cnt++;
    check_req("R5 split transfer", exp_cnt, a, d, 1'b1, 1'b0);

    // R7: aborted transfer is dropped
    m_xfer(8'hC1, 8'd8, 3, {32'h1111_2222, 32'h3333_4444}, aok);
    cyc(40);
    chk(req_cnt == exp_cnt && !req, "R7 no request on short transfer", 32'(req_cnt), 32'(exp_cnt));
    a = 32'h7788_99AA; d = 32'hBBCC_DDEE;
    m_xfer(8'h41, 8'd8, 8, {a, d}, aok);
    exp_cnt++;
    check_req("R7 refill from position 0", exp_cnt, a, d, 1'b1, 1'b0);

    // R6: busy refuses both directions
    resp_en = 1'b0;
    a = 32'h0F0E_0D0C; d = 32'h0B0A_0908;
    m_xfer(8'hC1, 8'd8, 8, {a, d}, aok);
    cyc(40);
    chk(req, "R4 request held without ack", {31'd0, req}, 32'd1);
    chk(addr == a && wdata == d, "R4 request fields", addr, a);
    m_start(); m_wr({DEV, 1'b0}, aok); m_stop();
    chk(!aok, "R6 write nak while busy", {31'd0, aok}, 32'd0);
    m_start(); m_wr({DEV, 1'b1}, aok); m_stop();
    chk(!aok, "R6 read nak while busy", {31'd0, aok}, 32'd0);
    resp_en = 1'b1;
    exp_cnt++;
    check_req("R4 served after busy", exp_cnt, a, d, 1'b1, 1'b0);
    chk(!req, "R4 request dropped after ack", {31'd0, req}, 32'd0);
    m_start(); m_wr({DEV, 1'b1}, aok); m_rd(1'b0, b); m_stop();
    chk(aok, "R6 address accepted after ack", {31'd0, aok}, 32'd1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule